// File: doc/BRIEF.md
# Per-Slot Interrupt Enable and Status Unit

This block keeps an interrupt-enable register and an interrupt-status register for each of several requester slots, and it drives one shared interrupt line. Event sources outside the block pulse a cause vector together with a slot number. The block records an event in that slot's status register only when the slot allows it. On a recorded event it asserts the shared line. Software acknowledges an event by writing ones to the status register.

Only the slot that currently owns the interface may write registers. Writes that carry any other slot number are dropped. A third, read-only vector register reports a fixed interrupt number. Reads have no side effects and return data one cycle after the address is presented. Event generation and bus address decoding are done elsewhere; this block receives a slot number and a register select.

Top module: `slot_irq_unit`

## Requirements
- R1: An event is recorded for a slot only when bit 31 (global enable) of that slot's enable register is set, and then only for the causes whose own enable bit is set. The `ev_cause` bits map to status and enable bits as follows: ev_cause[0] is data available (bit 0), ev_cause[1] is status valid (bit 1), ev_cause[2] is owner changed (bit 2), and ev_cause[3] is command ready (bit 7). Recording any cause raises `irq_o` in the same clock edge that updates the status register.
- R2: An event whose `ev_slot` is not below NUM_SLOTS changes no register and does not change `irq_o`.
- R3: Writing to the status register (select 1) clears each status bit that is written as 1. When the write leaves a previously non-zero status at zero, `irq_o` falls on that edge. When the status stays non-zero, `irq_o` stays high.
- R4: Writes to the enable or status register are ignored when `active_vld` is low or when `wr_slot` differs from `active_slot`.
- R5: An enable write can change only bit 31, the polarity field in bits 4:3, and the cause bits 7, 2, 1 and 0. Every other bit reads as 0.
- R6: After reset, every slot's enable register reads 0x00000008 (polarity field 01, active-low level), every status register reads 0, and `irq_o` is low.
- R7: The vector register (select 2) reads IRQ_NUM modulo 16 for every slot, and writes to it have no effect.
- R8: On an enable write, only the bytes whose `wr_be` bit is set are updated (wr_be[k] covers bits 8k+7:8k). Bytes whose `wr_be` bit is clear keep their value.
- R9: The shared line falls when the status of the slot being cleared reaches zero, even if another slot still holds status bits. If an event is recorded in the same cycle as such a clear, the line stays high.
- R10: `rd_data` shows the register picked by `rd_slot`/`rd_sel` one cycle after they are presented. Select 3, and any slot number not below NUM_SLOTS, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| active_vld | input | 1 | A slot currently owns the interface |
| active_slot | input | SLOT_W | Number of the owning slot |
| ev_valid | input | 1 | Event pulse |
| ev_slot | input | SLOT_W | Slot the event belongs to |
| ev_cause | input | 4 | Event causes (mapping in R1) |
| wr_en | input | 1 | Register write strobe |
| wr_slot | input | SLOT_W | Slot named by the write |
| wr_sel | input | 2 | 0 enable, 1 status, 2 vector, 3 reserved |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables for the write |
| rd_slot | input | SLOT_W | Slot to read |
| rd_sel | input | 2 | Register to read, same encoding as wr_sel |
| rd_data | output | 32 | Registered read data |
| irq_o | output | 1 | Shared interrupt line, active high |

## Verification
The bench builds the block with NUM_SLOTS = 5, SLOT_W = 3 and IRQ_NUM = 13. This leaves slot codes 5 to 7 unused. Events and reads sent to those codes show that they are dropped and read as zero. IRQ_NUM differs from its default, so the vector read back shows that the parameter reaches the register. With five slots, the bench can record status in one slot, move ownership to another slot, and clear there. This shows that the shared line follows only the slot being cleared, and that an event in the same cycle keeps the line high.

// File: rtl/slot_irq_pkg.sv
package slot_irq_pkg;
  localparam int REG_W   = 32;
  localparam int BE_W    = REG_W / 8;
  localparam int CAUSE_N = 4;

  // register bit positions of each event cause, indexed by ev_cause bit
  localparam int CAUSE_POS [CAUSE_N] = '{0, 1, 2, 7};

  localparam logic [REG_W-1:0] GEN_EN_MASK = 32'h8000_0000;
  localparam logic [REG_W-1:0] POL_MASK    = 32'h0000_0018;
  localparam logic [REG_W-1:0] CAUSE_MASK  = 32'h0000_0087;
  localparam logic [REG_W-1:0] EN_WR_MASK  = GEN_EN_MASK | POL_MASK | CAUSE_MASK;
  localparam logic [REG_W-1:0] EN_RST_VAL  = 32'h0000_0008;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_VECTOR = 2'd2,
    SEL_RSVD   = 2'd3
  } reg_sel_e;

  function automatic logic [REG_W-1:0] cause_to_bits(input logic [CAUSE_N-1:0] c);
    logic [REG_W-1:0] r;
    r = '0;
    for (int i = 0; i < CAUSE_N; i++) begin
      r[CAUSE_POS[i]] = c[i];
    end
    return r;
  endfunction
endpackage

// File: rtl/sirq_slot_regs.sv
module sirq_slot_regs
  import slot_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_hit,
  input  logic [REG_W-1:0] ev_bits,
  input  logic             en_wr,
  input  logic             sts_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic [BE_W-1:0]  be,
  output logic [REG_W-1:0] en_q,
  output logic [REG_W-1:0] sts_q,
  output logic             latch_o,
  output logic             drop_o
);
  logic [REG_W-1:0] bmask;
  logic [REG_W-1:0] ev_live;
  logic [REG_W-1:0] clr_bits;
  logic [REG_W-1:0] sts_kept;
  logic [REG_W-1:0] sts_d;
  logic [REG_W-1:0] en_d;

  for (genvar b = 0; b < BE_W; b++) begin : g_bmask
    assign bmask[8*b +: 8] = {8{be[b]}};
  end

  always_comb begin
    ev_live  = ev_bits & en_q & CAUSE_MASK;
    latch_o  = ev_hit && en_q[REG_W-1] && (|ev_live);
    clr_bits = sts_wr ? (wdata & CAUSE_MASK) : '0;
    sts_kept = sts_q & ~clr_bits;
    sts_d    = sts_kept | (latch_o ? ev_live : '0);
    drop_o   = sts_wr && (|sts_q) && !(|sts_kept);
    en_d     = en_wr ? ((en_q & ~bmask) | (wdata & bmask & EN_WR_MASK)) : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= EN_RST_VAL;
      sts_q <= '0;
    end else begin
      en_q  <= en_d;
      sts_q <= sts_d;
    end
  end

  AST_NO_LATCH_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!en_q[REG_W-1] && !sts_wr) |=> $stable(sts_q)); // R1
  AST_ONLY_ENABLED_CAUSE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(en_q)) == '0)); // R1
  AST_STS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!sts_wr && !ev_hit) |=> $stable(sts_q)); // R4
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en_wr |=> $stable(en_q)); // R4
  AST_EN_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((en_q & ~EN_WR_MASK) == '0)); // R5
endmodule

// File: rtl/sirq_line.sv
module sirq_line (
  input  logic clk,
  input  logic rst,
  input  logic any_set,
  input  logic any_drop,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst)           irq_q <= 1'b0;
    else if (any_set)  irq_q <= 1'b1;
    else if (any_drop) irq_q <= 1'b0;
  end

  AST_RAISE_ON_LATCH: assert property (@(posedge clk) disable iff (rst)
    any_set |=> irq_q); // R1
  AST_DROP_ON_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (any_drop && !any_set) |=> !irq_q); // R9
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!any_set && !any_drop) |=> $stable(irq_q)); // R3
endmodule

// File: rtl/sirq_rdmux.sv
module sirq_rdmux
  import slot_irq_pkg::*;
#(
  parameter int NUM_SLOTS = 5,
  parameter int SLOT_W    = 3,
  parameter logic [REG_W-1:0] VEC_VALUE = 32'd10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] en_arr  [NUM_SLOTS],
  input  logic [REG_W-1:0] sts_arr [NUM_SLOTS],
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [1:0]       rd_sel,
  output logic [REG_W-1:0] rd_data
);
  logic [REG_W-1:0] en_pick;
  logic [REG_W-1:0] sts_pick;
  logic [REG_W-1:0] rd_d;

  always_comb begin
    en_pick  = '0;
    sts_pick = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (rd_slot == SLOT_W'(i)) begin
        en_pick  = en_arr[i];
        sts_pick = sts_arr[i];
      end
    end
    unique case (reg_sel_e'(rd_sel))
      SEL_ENABLE: rd_d = en_pick;
      SEL_STATUS: rd_d = sts_pick;
      SEL_VECTOR: rd_d = (32'(rd_slot) < 32'(NUM_SLOTS)) ? VEC_VALUE : '0;
      default:    rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_d;
  end

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == 2'd3) |=> (rd_data == '0)); // R10
endmodule

// File: rtl/slot_irq_unit.sv
module slot_irq_unit
  import slot_irq_pkg::*;
#(
  parameter int NUM_SLOTS = 5,
  parameter int SLOT_W    = 3,
  parameter int IRQ_NUM   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active_vld,
  input  logic [SLOT_W-1:0] active_slot,
  input  logic              ev_valid,
  input  logic [SLOT_W-1:0] ev_slot,
  input  logic [CAUSE_N-1:0] ev_cause,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [1:0]        wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [1:0]        rd_sel,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq_o
);
  localparam logic [REG_W-1:0] VEC_VALUE = REG_W'(IRQ_NUM % 16);

  logic [REG_W-1:0] ev_bits;
  logic             owner_ok;
  logic [REG_W-1:0] en_arr  [NUM_SLOTS];
  logic [REG_W-1:0] sts_arr [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] latch_v;
  logic [NUM_SLOTS-1:0] drop_v;

  assign ev_bits  = cause_to_bits(ev_cause);
  assign owner_ok = wr_en && active_vld && (wr_slot == active_slot);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic sel_hit;
    assign sel_hit = owner_ok && (wr_slot == SLOT_W'(s));
    sirq_slot_regs u_regs (
      .clk     (clk),
      .rst     (rst),
      .ev_hit  (ev_valid && (ev_slot == SLOT_W'(s))),
      .ev_bits (ev_bits),
      .en_wr   (sel_hit && (wr_sel == SEL_ENABLE)),
      .sts_wr  (sel_hit && (wr_sel == SEL_STATUS)),
      .wdata   (wr_data),
      .be      (wr_be),
      .en_q    (en_arr[s]),
      .sts_q   (sts_arr[s]),
      .latch_o (latch_v[s]),
      .drop_o  (drop_v[s])
    );
  end

  sirq_line u_line (
    .clk      (clk),
    .rst      (rst),
    .any_set  (|latch_v),
    .any_drop (|drop_v),
    .irq_q    (irq_o)
  );

  sirq_rdmux #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W),
    .VEC_VALUE (VEC_VALUE)
  ) u_rd (
    .clk     (clk),
    .rst     (rst),
    .en_arr  (en_arr),
    .sts_arr (sts_arr),
    .rd_slot (rd_slot),
    .rd_sel  (rd_sel),
    .rd_data (rd_data)
  );

  AST_VECTOR_FIXED: assert property (@(posedge clk) disable iff (rst)
    ((rd_sel == 2'd2) && (32'(rd_slot) < 32'(NUM_SLOTS))) |=> (rd_data == VEC_VALUE)); // R7
  AST_BAD_SLOT_EVENT: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && (32'(ev_slot) >= 32'(NUM_SLOTS)) && !wr_en) |=> $stable(irq_o)); // R2
  AST_NONOWNER_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !owner_ok && !ev_valid) |=> $stable(irq_o)); // R4
endmodule

// File: tb/tb_slot_irq_unit.sv
module tb_slot_irq_unit;
  localparam int NS = 5;
  localparam int SW = 3;
  localparam int IRQN = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic active_vld = 1'b0;
  logic [SW-1:0] active_slot = '0;
  logic ev_valid = 1'b0;
  logic [SW-1:0] ev_slot = '0;
  logic [3:0] ev_cause = '0;
  logic wr_en = 1'b0;
  logic [SW-1:0] wr_slot = '0;
  logic [1:0] wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [3:0] wr_be = '0;
  logic [SW-1:0] rd_slot = '0;
  logic [1:0] rd_sel = '0;
  logic [31:0] rd_data;
  logic irq_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  slot_irq_unit #(.NUM_SLOTS(NS), .SLOT_W(SW), .IRQ_NUM(IRQN)) dut (
    .clk(clk), .rst(rst), .active_vld(active_vld), .active_slot(active_slot),
    .ev_valid(ev_valid), .ev_slot(ev_slot), .ev_cause(ev_cause),
    .wr_en(wr_en), .wr_slot(wr_slot), .wr_sel(wr_sel), .wr_data(wr_data), .wr_be(wr_be),
    .rd_slot(rd_slot), .rd_sel(rd_sel), .rd_data(rd_data), .irq_o(irq_o));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input int s, input logic [1:0] sel, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_slot = SW'(s); wr_sel = sel; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_ev(input int s, input logic [3:0] c);
    @(negedge clk);
    ev_valid = 1'b1; ev_slot = SW'(s); ev_cause = c;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic do_rd(input int s, input logic [1:0] sel, output logic [31:0] v);
    @(negedge clk);
    rd_slot = SW'(s); rd_sel = sel;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic own(input int s);
    @(negedge clk);
    active_vld = 1'b1; active_slot = SW'(s);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk({31'b0, irq_o}, 32'd0, "R6 irq after reset");
    for (int s = 0; s < NS; s++) begin
      do_rd(s, 2'd0, v); chk(v, 32'h8, "R6 enable reset");
      do_rd(s, 2'd1, v); chk(v, 32'h0, "R6 status reset");
    end
    do_rd(0, 2'd2, v); chk(v, 32'd13, "R7 vector value");
  endtask

  task automatic t_bad_slot;
    logic [31:0] v;
    own(1);
    do_wr(1, 2'd0, 32'h8000_0087, 4'hF);
    do_ev(6, 4'hF);
    chk({31'b0, irq_o}, 32'd0, "R2 invalid slot event irq");
    do_ev(5, 4'hF);
    chk({31'b0, irq_o}, 32'd0, "R2 slot 5 event irq");
    do_rd(1, 2'd1, v); chk(v, 32'h0, "R2 slot1 status untouched");
    do_rd(7, 2'd0, v); chk(v, 32'h0, "R10 invalid slot read");
  endtask

  task automatic t_gate;
    logic [31:0] v;
    do_wr(1, 2'd0, 32'h8000_0001, 4'hF);
    do_ev(1, 4'b0010);
    do_rd(1, 2'd1, v); chk(v, 32'h0, "R1 disabled cause not recorded");
    chk({31'b0, irq_o}, 32'd0, "R1 no irq for disabled cause");
    do_wr(1, 2'd0, 32'h0000_0003, 4'hF);
    do_ev(1, 4'b0011);
    do_rd(1, 2'd1, v); chk(v, 32'h0, "R1 global enable off");
    do_wr(1, 2'd0, 32'h8000_0003, 4'hF);
    do_ev(1, 4'b0111);
    chk({31'b0, irq_o}, 32'd1, "R1 irq raised");
    do_rd(1, 2'd1, v); chk(v, 32'h3, "R1 only enabled causes");
  endtask

  task automatic t_nonowner;
    logic [31:0] v;
    do_wr(2, 2'd0, 32'h8000_0085, 4'hF);
    do_rd(2, 2'd0, v); chk(v, 32'h8, "R4 non-owner enable write");
    @(negedge clk); active_vld = 1'b0;
    do_wr(1, 2'd1, 32'h3, 4'hF);
    do_rd(1, 2'd1, v); chk(v, 32'h3, "R4 write with no owner");
    chk({31'b0, irq_o}, 32'd1, "R4 irq unchanged");
    own(1);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    do_wr(1, 2'd0, 32'hFFFF_FFFF, 4'hF);
    do_rd(1, 2'd0, v); chk(v, 32'h8000_009F, "R5 writable bits");
    do_wr(1, 2'd0, 32'h0, 4'b0001);
    do_rd(1, 2'd0, v); chk(v, 32'h8000_0000, "R8 low byte only");
    do_wr(1, 2'd0, 32'h0000_FF00, 4'b0010);
    do_rd(1, 2'd0, v); chk(v, 32'h8000_0000, "R5 byte1 has no writable bit");
    do_wr(1, 2'd0, 32'h0, 4'b1000);
    do_rd(1, 2'd0, v); chk(v, 32'h0, "R8 top byte only");
    do_wr(1, 2'd0, 32'h8000_0087, 4'hF);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    do_ev(1, 4'b1000);
    do_rd(1, 2'd1, v); chk(v, 32'h83, "R1 command ready on bit 7");
    do_wr(1, 2'd1, 32'h1, 4'hF);
    do_rd(1, 2'd1, v); chk(v, 32'h82, "R3 partial clear");
    chk({31'b0, irq_o}, 32'd1, "R3 irq stays with status left");
    do_wr(1, 2'd1, 32'h82, 4'hF);
    do_rd(1, 2'd1, v); chk(v, 32'h0, "R3 full clear");
    chk({31'b0, irq_o}, 32'd0, "R3 irq falls at zero");
  endtask

  task automatic t_shared;
    logic [31:0] v;
    do_ev(1, 4'b0001);
    chk({31'b0, irq_o}, 32'd1, "R9 slot1 raises");
    own(3);
    do_wr(3, 2'd0, 32'h8000_0004, 4'hF);
    do_ev(3, 4'b0100);
    do_wr(3, 2'd1, 32'h4, 4'hF);
    chk({31'b0, irq_o}, 32'd0, "R9 drop on clearing slot");
    do_rd(1, 2'd1, v); chk(v, 32'h1, "R9 other slot keeps status");
    own(1);
    @(negedge clk);
    wr_en = 1'b1; wr_slot = SW'(1); wr_sel = 2'd1; wr_data = 32'h1; wr_be = 4'hF;
    ev_valid = 1'b1; ev_slot = SW'(3); ev_cause = 4'b0100;
    @(negedge clk);
    wr_en = 1'b0; ev_valid = 1'b0;
    chk({31'b0, irq_o}, 32'd1, "R9 event wins over drop");
    do_rd(1, 2'd1, v); chk(v, 32'h0, "R3 slot1 cleared");
    do_rd(3, 2'd1, v); chk(v, 32'h4, "R9 slot3 recorded");
  endtask

  task automatic t_vector;
    logic [31:0] v;
    do_wr(1, 2'd2, 32'h5, 4'hF);
    do_rd(1, 2'd2, v); chk(v, 32'd13, "R7 vector write ignored");
    do_rd(4, 2'd2, v); chk(v, 32'd13, "R7 vector other slot");
    do_rd(1, 2'd3, v); chk(v, 32'h0, "R10 reserved select");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_bad_slot();
    t_gate();
    t_nonowner();
    t_mask();
    t_w1c();
    t_shared();
    t_vector();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule